// File: doc/BRIEF.md
# Command queue trigger controller

This block sits beside one command FIFO of a conversion sequencer. It decides in which cycles the FIFO may hand its head command to the conversion buffer. It supports six trigger modes. Each mode is either single-scan or continuous-scan, and each is started by software, by an edge of the trigger input, or by the level of that input acting as a gate. The block tracks the queue status (idle, waiting for trigger, triggered) and applies each mode's stop rules for the end-of-queue and pause markers carried by every command.

Software selects a mode and a trigger polarity. For single-scan modes it pulses the arm input. An external arbiter supplies the grant, which says this queue currently has the highest priority, and the buffer supplies its full indication. A transfer is a single-cycle handshake: `cmd_pop` and `xfer_valid` rise together and `xfer_data` carries the command. Three sticky flags record end-of-queue, pause and trigger overrun. Each flag has its own interrupt enable.

Top module: `cmdq_trig_ctrl`

## Requirements
- R1: After reset, `q_status` is idle, `armed` is 0 and all flags are 0. `q_status` codes are 0 idle, 1 waiting, 2 triggered. `mode_sel` encodes bit 2 = continuous scan, and bits 1:0 are 00 off, 01 software, 10 edge, 11 level. A new `mode_sel` value takes effect one clock later. Any change returns the status to idle and clears the arm bit, unless `arm_set` is high in that cycle.
- R2: `xfer_valid` and `cmd_pop` are 1, with `xfer_data` equal to `cmd_data`, exactly when all of these hold: the status is triggered, `cmd_valid` and `grant` are 1, and `buf_full` is 0. In level modes the gate must also be open.
- R3: `trig_in` passes through two flip-flops before use. With `trig_pol`=0, a rising edge is the trigger edge and a high level opens the gate. With `trig_pol`=1, a falling edge is the trigger edge and a low level opens the gate.
- R4: In single-scan software mode, a set arm bit moves the queue from idle to triggered. A transferred end-of-queue command returns the queue to idle and clears the arm bit. The pause marker has no effect.
- R5: Single-scan edge and level modes leave idle for waiting only while armed, and trigger edges seen while idle are ignored. Continuous edge and level modes go from idle to waiting with no arm bit. In waiting, a trigger edge (edge modes) or an open gate (level modes) moves the queue to triggered.
- R6: In edge modes, a transferred pause command sets the pause flag and moves the queue to waiting. A transferred end-of-queue command moves the queue to idle (single-scan) or to waiting (continuous), and no re-arm is needed before the next edge is recognised.
- R7: In edge modes, a trigger edge detected while the queue is triggered sets the overrun flag.
- R8: In level modes, a closed gate while triggered blocks transfers, moves the queue to waiting and sets the pause flag. The queue returns to triggered when the gate reopens. In single-scan level mode, the pause marker has no effect and end-of-queue returns the queue to idle.
- R9: In continuous level mode, a transferred end-of-queue command sets the end-of-queue flag but the queue stays triggered. The pause marker has no effect.
- R10: Continuous software mode goes from idle to triggered without an arm bit. It never leaves triggered because of end-of-queue or pause markers.
- R11: `flags` bit 0 is end-of-queue, bit 1 is pause and bit 2 is overrun. Bit 0 is set by every transferred command carrying the end-of-queue marker. Flags stay set until the matching `flag_clr` bit is 1; a set in the same cycle wins over the clear. `irq` equals `flags & irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Trigger mode select |
| trig_pol | input | 1 | Trigger polarity (0 rising/high, 1 falling/low) |
| trig_in | input | 1 | Asynchronous trigger input |
| arm_set | input | 1 | Single-scan arm request |
| cmd_valid | input | 1 | FIFO has a command at its head |
| cmd_data | input | CMD_W | Head command payload |
| cmd_eoq | input | 1 | Head command carries the end-of-queue marker |
| cmd_pause | input | 1 | Head command carries the pause marker |
| grant | input | 1 | This queue holds the highest-priority grant |
| buf_full | input | 1 | Target conversion buffer is full |
| flag_clr | input | 3 | Per-flag clear |
| irq_en | input | 3 | Per-flag interrupt enable |
| cmd_pop | output | 1 | Head command is taken this cycle |
| xfer_valid | output | 1 | Command is delivered to the buffer this cycle |
| xfer_data | output | CMD_W | Delivered command |
| q_status | output | 2 | Queue status |
| armed | output | 1 | Arm bit |
| flags | output | 3 | Sticky event flags |
| irq | output | 3 | Interrupt requests |

## Verification
On every cycle, the assertions check these rules:
- the status never takes its unused code;
- a single-scan end-of-queue transfer always lands in idle with the arm bit clear;
- continuous software mode never drops out of triggered;
- a closed gate always pulls a triggered level-mode queue back to waiting;
- each detected edge follows a closed-gate sample;
- flags are sticky;
- overrun rises only from the triggered state.

The other behaviour shows only in the bench's scenarios, where a behavioural model is compared with the outputs on every clock. This covers which markers stop which mode, the need for an arm bit in single-scan modes, the edges ignored while idle, resumption after pause, the precedence of set over clear, and the restart on a mode change.

// File: rtl/cmdq_trig_pkg.sv
`timescale 1ns/1ps
package cmdq_trig_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_TRIG = 2'd2
   } qstat_e;

   typedef enum logic [1:0] {
      TK_OFF   = 2'd0,
      TK_SW    = 2'd1,
      TK_EDGE  = 2'd2,
      TK_LEVEL = 2'd3
   } tkind_e;

   localparam int MODE_W   = 3;
   localparam int NFLAG    = 3;
   localparam int FL_EOQ   = 0;
   localparam int FL_PAUSE = 1;
   localparam int FL_OVR   = 2;
endpackage

// File: rtl/cmdq_trig_sync.sv
`timescale 1ns/1ps
module cmdq_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   input  logic trig_pol,
   output logic gate_open,
   output logic edge_hit
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("cmdq_trig_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   // R3: synchroniser chain plus one history flop for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], trig_in};
         prev_q  <= chain_q[LAST];
      end
   end

   assign gate_open = chain_q[LAST] ^ trig_pol;
   assign edge_hit  = gate_open & ~(prev_q ^ trig_pol);

   AST_EDGE_AFTER_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit && $stable(trig_pol)) |-> !$past(gate_open)); // R3
endmodule

// File: rtl/cmdq_trig_flags.sv
`timescale 1ns/1ps
module cmdq_trig_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] en_i,
   output logic [N-1:0] flag_o,
   output logic [N-1:0] irq_o
);
   if (N < 1) begin : g_bad_n
      $error("cmdq_trig_flags: N must be positive");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic bit_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        bit_q <= 1'b0;
         else if (set_i[i]) bit_q <= 1'b1;
         else if (clr_i[i]) bit_q <= 1'b0;
      end

      assign flag_o[i] = bit_q;
      assign irq_o[i]  = bit_q & en_i[i];

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (bit_q && !clr_i[i]) |=> bit_q); // R11
   end
endmodule

// File: rtl/cmdq_trig_fsm.sv
`timescale 1ns/1ps
module cmdq_trig_fsm
   import cmdq_trig_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic              arm_set,
   input  logic              gate_open,
   input  logic              edge_hit,
   input  logic              cmd_valid,
   input  logic              cmd_eoq,
   input  logic              cmd_pause,
   input  logic              grant,
   input  logic              buf_full,
   output qstat_e            status,
   output logic              armed,
   output logic              fire,
   output logic [NFLAG-1:0]  flag_set
);
   logic [MODE_W-1:0] mode_q;
   qstat_e            status_q, status_d;
   logic              arm_q;
   tkind_e            kind;
   logic              cont, mode_chg, gate_ok;
   logic              eoq_stop, pause_stop, gate_shut;

   assign kind     = tkind_e'(mode_q[1:0]);
   assign cont     = mode_q[MODE_W-1];
   assign mode_chg = (mode_sel != mode_q);
   assign gate_ok  = (kind != TK_LEVEL) || gate_open;

   // R2: single-cycle transfer handshake
   assign fire = (status_q == ST_TRIG) && cmd_valid && grant && !buf_full && gate_ok;

   assign eoq_stop   = fire && cmd_eoq && (!cont || kind == TK_EDGE);
   assign pause_stop = fire && cmd_pause && (kind == TK_EDGE);
   assign gate_shut  = (kind == TK_LEVEL) && !gate_open;

   always_comb begin
      status_d = status_q;
      if (mode_chg) begin
         status_d = ST_IDLE;
      end else begin
         case (status_q)
            ST_IDLE: begin
               if (kind == TK_SW) begin
                  if (cont || arm_q) status_d = ST_TRIG;
               end else if (kind != TK_OFF) begin
                  if (cont || arm_q) status_d = ST_WAIT;
               end
            end
            ST_WAIT: begin
               if ((kind == TK_EDGE && edge_hit) || (kind == TK_LEVEL && gate_open))
                  status_d = ST_TRIG;
            end
            ST_TRIG: begin
               if (eoq_stop)        status_d = cont ? ST_WAIT : ST_IDLE;
               else if (pause_stop) status_d = ST_WAIT;
               else if (gate_shut)  status_d = ST_WAIT;
            end
            default: status_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         status_q <= ST_IDLE;
         arm_q    <= 1'b0;
      end else begin
         mode_q   <= mode_sel;
         status_q <= status_d;
         if (arm_set)                                    arm_q <= 1'b1;
         else if (mode_chg || (fire && cmd_eoq && !cont)) arm_q <= 1'b0;
      end
   end

   always_comb begin
      flag_set           = '0;
      flag_set[FL_EOQ]   = fire && cmd_eoq;
      flag_set[FL_PAUSE] = (pause_stop && !cmd_eoq) || ((status_q == ST_TRIG) && gate_shut);
      flag_set[FL_OVR]   = (status_q == ST_TRIG) && (kind == TK_EDGE) && edge_hit;
   end

   assign status = status_q;
   assign armed  = arm_q;

   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      status_q != 2'd3); // R1
   AST_SS_EOQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cmd_eoq && !cont && !mode_chg) |=> status_q == ST_IDLE); // R4
   AST_SS_EOQ_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cmd_eoq && !cont && !arm_set) |=> !arm_q); // R4
   AST_CS_SW_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'b101 && !mode_chg && status_q == ST_TRIG) |=> status_q == ST_TRIG); // R10
   AST_GATE_CLOSE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q == ST_TRIG && gate_shut && !mode_chg) |=> status_q == ST_WAIT); // R8
endmodule

// File: rtl/cmdq_trig_ctrl.sv
`timescale 1ns/1ps
module cmdq_trig_ctrl
   import cmdq_trig_pkg::*;
#(
   parameter int CMD_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_sel,
   input  logic              trig_pol,
   input  logic              trig_in,
   input  logic              arm_set,
   input  logic              cmd_valid,
   input  logic [CMD_W-1:0]  cmd_data,
   input  logic              cmd_eoq,
   input  logic              cmd_pause,
   input  logic              grant,
   input  logic              buf_full,
   input  logic [2:0]        flag_clr,
   input  logic [2:0]        irq_en,
   output logic              cmd_pop,
   output logic              xfer_valid,
   output logic [CMD_W-1:0]  xfer_data,
   output logic [1:0]        q_status,
   output logic              armed,
   output logic [2:0]        flags,
   output logic [2:0]        irq
);
   if (CMD_W < 1) begin : g_bad_width
      $error("cmdq_trig_ctrl: CMD_W must be positive");
   end

   logic             gate_open, edge_hit, fire;
   qstat_e           status_w;
   logic [NFLAG-1:0] flag_set, flag_w;

   cmdq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_in   (trig_in),
      .trig_pol  (trig_pol),
      .gate_open (gate_open),
      .edge_hit  (edge_hit)
   );

   cmdq_trig_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sel  (mode_sel),
      .arm_set   (arm_set),
      .gate_open (gate_open),
      .edge_hit  (edge_hit),
      .cmd_valid (cmd_valid),
      .cmd_eoq   (cmd_eoq),
      .cmd_pause (cmd_pause),
      .grant     (grant),
      .buf_full  (buf_full),
      .status    (status_w),
      .armed     (armed),
      .fire      (fire),
      .flag_set  (flag_set)
   );

   cmdq_trig_flags #(.N(NFLAG)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set),
      .clr_i  (flag_clr),
      .en_i   (irq_en),
      .flag_o (flag_w),
      .irq_o  (irq)
   );

   assign cmd_pop    = fire;
   assign xfer_valid = fire;
   assign xfer_data  = cmd_data;
   assign q_status   = status_w;
   assign flags      = flag_w;

   AST_OVR_FROM_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_w[FL_OVR]) |-> $past(status_w) == ST_TRIG); // R7
endmodule

// File: tb/cmdq_trig_ctrl_test.sv
`timescale 1ns/1ps
module cmdq_trig_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_sel = 3'b000;
   logic        trig_pol = 1'b0;
   logic        trig_in = 1'b0;
   logic        arm_set = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_data = 16'h0;
   logic        cmd_eoq = 1'b0;
   logic        cmd_pause = 1'b0;
   logic        grant = 1'b0;
   logic        buf_full = 1'b0;
   logic [2:0]  flag_clr = 3'b000;
   logic [2:0]  irq_en = 3'b000;
   logic        cmd_pop, xfer_valid;
   logic [15:0] xfer_data;
   logic [1:0]  q_status;
   logic        armed;
   logic [2:0]  flags, irq;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   cmdq_trig_ctrl uut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .trig_pol(trig_pol),
      .trig_in(trig_in), .arm_set(arm_set), .cmd_valid(cmd_valid),
      .cmd_data(cmd_data), .cmd_eoq(cmd_eoq), .cmd_pause(cmd_pause),
      .grant(grant), .buf_full(buf_full), .flag_clr(flag_clr), .irq_en(irq_en),
      .cmd_pop(cmd_pop), .xfer_valid(xfer_valid), .xfer_data(xfer_data),
      .q_status(q_status), .armed(armed), .flags(flags), .irq(irq)
   );

   always #10 clk = ~clk;

   // behavioural reference model
   logic [2:0] m_mode;
   logic [1:0] m_stat;
   logic       m_arm;
   logic [2:0] m_flag;
   logic       ms1, ms2, mprev;

   function automatic logic m_fire_now();
      logic lvl;
      lvl = (m_mode[1:0] == 2'd3);
      return (m_stat == 2'd2) && cmd_valid && grant && !buf_full && (!lvl || (ms2 ^ trig_pol));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      int k;
      logic cont, gate, edg, f, chg;
      logic [1:0] ns;
      logic [2:0] setf;
      if (!rst_n) begin
         m_mode = 3'd0; m_stat = 2'd0; m_arm = 1'b0; m_flag = 3'd0;
         ms1 = 1'b0; ms2 = 1'b0; mprev = 1'b0;
      end else begin
         k    = int'(m_mode[1:0]);
         cont = m_mode[2];
         gate = ms2 ^ trig_pol;
         edg  = gate && !(mprev ^ trig_pol);
         f    = m_fire_now();
         chg  = (mode_sel != m_mode);
         setf = 3'd0;
         ns   = m_stat;
         if (f && cmd_eoq) setf[0] = 1'b1;
         if (m_stat == 2'd2 && k == 2 && f && cmd_pause && !cmd_eoq) setf[1] = 1'b1;
         if (m_stat == 2'd2 && k == 3 && !gate) setf[1] = 1'b1;
         if (m_stat == 2'd2 && k == 2 && edg) setf[2] = 1'b1;
         if (chg) ns = 2'd0;
         else if (m_stat == 2'd0) begin
            if (k == 1 && (cont || m_arm)) ns = 2'd2;
            else if (k >= 2 && (cont || m_arm)) ns = 2'd1;
         end else if (m_stat == 2'd1) begin
            if ((k == 2 && edg) || (k == 3 && gate)) ns = 2'd2;
         end else begin
            if (f && cmd_eoq && (!cont || k == 2)) ns = cont ? 2'd1 : 2'd0;
            else if (f && cmd_pause && k == 2) ns = 2'd1;
            else if (k == 3 && !gate) ns = 2'd1;
         end
         if (arm_set) m_arm = 1'b1;
         else if (chg || (f && cmd_eoq && !cont)) m_arm = 1'b0;
         m_flag = (m_flag & ~flag_clr) | setf;
         m_stat = ns;
         mprev  = ms2;
         ms2    = ms1;
         ms1    = trig_in;
         m_mode = mode_sel;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(posedge clk) begin
      logic f;
      #5;
      if (rst_n && !done) begin
         f = m_fire_now();
         chk("R1 status", {30'd0, q_status}, {30'd0, m_stat});
         chk("R5 armed", {31'd0, armed}, {31'd0, m_arm});
         chk("R2 xfer_valid", {30'd0, xfer_valid, cmd_pop}, {30'd0, f, f});
         if (f) chk("R2 xfer_data", {16'd0, xfer_data}, {16'd0, cmd_data});
         chk("R11 flags", {29'd0, flags}, {29'd0, m_flag});
         chk("R11 irq", {29'd0, irq}, {29'd0, m_flag & irq_en});
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_arm();
      @(negedge clk); arm_set = 1'b1;
      @(negedge clk); arm_set = 1'b0;
   endtask

   task automatic clear_flags();
      @(negedge clk); flag_clr = 3'b111;
      @(negedge clk); flag_clr = 3'b000;
   endtask

   task automatic send(input logic [15:0] d, input logic e, input logic p);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_data = d; cmd_eoq = e; cmd_pause = p;
      for (int i = 0; i < 30; i++) begin
         #1;
         if (cmd_pop) break;
         @(negedge clk);
      end
      @(negedge clk);
      cmd_valid = 1'b0; cmd_eoq = 1'b0; cmd_pause = 1'b0;
      #1;
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog R1 act=timeout exp=finished");
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1); #1;
      chk("R1 reset status", {30'd0, q_status}, 32'd0);
      chk("R1 reset armed", {31'd0, armed}, 32'd0);
      chk("R1 reset flags", {29'd0, flags}, 32'd0);
      grant = 1'b1;

      // single-scan software
      mode_sel = 3'b001; cyc(3); #1;
      chk("R1 sw idle before arm", {30'd0, q_status}, 32'd0);
      pulse_arm(); cyc(1); #1;
      chk("R4 armed triggers", {30'd0, q_status}, 32'd2);
      @(negedge clk); cmd_valid = 1'b1; cmd_data = 16'hAAAA; buf_full = 1'b1; #1;
      chk("R2 full blocks", {31'd0, cmd_pop}, 32'd0);
      @(negedge clk); buf_full = 1'b0; #1;
      chk("R2 transfer", {15'd0, cmd_pop, xfer_data}, {15'd0, 1'b1, 16'hAAAA});
      @(negedge clk); cmd_valid = 1'b0;
      send(16'h0101, 1'b0, 1'b1);
      chk("R4 pause ignored", {29'd0, flags[1], q_status}, {29'd0, 1'b0, 2'd2});
      send(16'h0102, 1'b1, 1'b0);
      chk("R4 eoq to idle", {29'd0, armed, q_status}, 32'd0);
      chk("R11 eoq flag", {31'd0, flags[0]}, 32'd1);
      cyc(4); #1;
      chk("R4 stays idle", {30'd0, q_status}, 32'd0);
      clear_flags();

      // single-scan edge, rising
      mode_sel = 3'b010; trig_pol = 1'b0; trig_in = 1'b0; cyc(3);
      trig_in = 1'b1; cyc(5); #1;
      chk("R5 unarmed edge ignored", {30'd0, q_status}, 32'd0);
      trig_in = 1'b0; cyc(4);
      pulse_arm(); cyc(2); #1;
      chk("R5 armed waits", {30'd0, q_status}, 32'd1);
      @(negedge clk); trig_in = 1'b1; cyc(5); #1;
      chk("R3 rising edge triggers", {30'd0, q_status}, 32'd2);
      send(16'h0201, 1'b0, 1'b1);
      chk("R6 pause stops", {29'd0, flags[1], q_status}, {29'd0, 1'b1, 2'd1});
      trig_in = 1'b0; cyc(4); trig_in = 1'b1; cyc(5); #1;
      chk("R6 edge resumes", {30'd0, q_status}, 32'd2);
      trig_in = 1'b0; cyc(4); trig_in = 1'b1; cyc(5); #1;
      chk("R7 overrun", {29'd0, flags[2], q_status}, {29'd0, 1'b1, 2'd2});
      send(16'h0202, 1'b1, 1'b1);
      chk("R6 ss eoq idle", {29'd0, armed, q_status}, 32'd0);
      clear_flags();

      // continuous edge, falling
      trig_in = 1'b1; trig_pol = 1'b1; mode_sel = 3'b110; cyc(5); #1;
      chk("R5 continuous waits unarmed", {30'd0, q_status}, 32'd1);
      @(negedge clk); trig_in = 1'b0; cyc(5); #1;
      chk("R3 falling edge triggers", {30'd0, q_status}, 32'd2);
      send(16'h0301, 1'b1, 1'b0);
      chk("R6 cs eoq waits", {29'd0, flags[0], q_status}, {29'd0, 1'b1, 2'd1});
      trig_in = 1'b1; cyc(4); trig_in = 1'b0; cyc(5); #1;
      chk("R6 no rearm needed", {30'd0, q_status}, 32'd2);
      clear_flags();

      // single-scan level, high opens
      trig_pol = 1'b0; trig_in = 1'b0; mode_sel = 3'b011; cyc(3);
      pulse_arm(); cyc(2); #1;
      chk("R5 level armed waits", {30'd0, q_status}, 32'd1);
      @(negedge clk); trig_in = 1'b1; cyc(5); #1;
      chk("R8 gate opens", {30'd0, q_status}, 32'd2);
      send(16'h0401, 1'b0, 1'b1);
      chk("R8 pause no effect", {29'd0, flags[1], q_status}, {29'd0, 1'b0, 2'd2});
      @(negedge clk); cmd_valid = 1'b1; cmd_data = 16'h0402; trig_in = 1'b0;
      cyc(6); cmd_valid = 1'b0; #1;
      chk("R8 gate close waits", {29'd0, flags[1], q_status}, {29'd0, 1'b1, 2'd1});
      trig_in = 1'b1; cyc(5); #1;
      chk("R8 gate reopens", {30'd0, q_status}, 32'd2);
      send(16'h0403, 1'b1, 1'b0);
      chk("R8 eoq idle", {29'd0, armed, q_status}, 32'd0);
      clear_flags();

      // continuous level, low opens
      trig_pol = 1'b1; trig_in = 1'b1; mode_sel = 3'b111; cyc(5); #1;
      chk("R8 closed gate waits", {30'd0, q_status}, 32'd1);
      @(negedge clk); trig_in = 1'b0; cyc(5); #1;
      chk("R3 low level opens", {30'd0, q_status}, 32'd2);
      send(16'h0501, 1'b1, 1'b0);
      chk("R9 eoq continues", {29'd0, flags[0], q_status}, {29'd0, 1'b1, 2'd2});
      send(16'h0502, 1'b0, 1'b1);
      chk("R9 pause no effect", {29'd0, flags[1], q_status}, {29'd0, 1'b0, 2'd2});
      clear_flags();

      // continuous software
      mode_sel = 3'b101; cyc(4); #1;
      chk("R10 starts unarmed", {29'd0, armed, q_status}, {29'd0, 1'b0, 2'd2});
      send(16'h0601, 1'b1, 1'b1);
      chk("R10 markers no stop", {28'd0, flags[1:0], q_status}, {28'd0, 2'b01, 2'd2});
      @(negedge clk); cmd_valid = 1'b1;
      for (int i = 0; i < 10; i++) begin
         cmd_data = 16'h0700 + 16'(i); grant = i[0]; buf_full = (i == 4);
         @(negedge clk);
      end
      cmd_valid = 1'b0; grant = 1'b1; buf_full = 1'b0; #1;
      chk("R10 still triggered", {30'd0, q_status}, 32'd2);

      // flags and interrupts
      irq_en = 3'b001; #1;
      chk("R11 irq enabled", {29'd0, irq}, 32'd1);
      @(negedge clk); flag_clr = 3'b001;
      @(negedge clk); flag_clr = 3'b000; #1;
      chk("R11 clear", {29'd0, flags, irq}, 32'd0);
      @(negedge clk); cmd_valid = 1'b1; cmd_eoq = 1'b1; flag_clr = 3'b001;
      @(negedge clk); cmd_valid = 1'b0; cmd_eoq = 1'b0; flag_clr = 3'b000; #1;
      chk("R11 set wins", {31'd0, flags[0]}, 32'd1);

      // mode change restarts
      @(negedge clk); mode_sel = 3'b001; cyc(2); #1;
      chk("R1 mode change idles", {30'd0, q_status}, 32'd0);

      cyc(3);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule